// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar in packed BCD bytes: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A sub-second divider counts pulses of a 32.768 kHz clock-enable input. Each time the divider wraps, the time advances by one second. The divider's top bit is brought out as a 1 Hz square-wave phase.

The hours byte can hold either a 24-hour value or a 12-hour value with an AM/PM flag. The day of month rolls over at the true length of each month, and every year divisible by four is a leap year. The host loads any field through a byte-wide write port. A halt input freezes both the divider and the time.

Writing the seconds field restarts the divider, so the next second lands exactly one full second after the write. Entries outside the legal ranges lead to undefined behaviour.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read as follows: seconds 8'h00, minutes 8'h00, hours 8'h00 (24-hour midnight), day of week 8'h01, day of month 8'h01, month 8'h01 with the century flag clear, year 8'h00. The square-wave phase is 0.
- R2: Seconds and minutes count in BCD from 00 to 59. Each wrap from 59 to 00 carries one unit into the next field.
- R3: When hours bit 6 is 0 (24-hour mode), bits 5:0 hold BCD 00 to 23. The step from 23 to 00 is midnight.
- R4: When hours bit 6 is 1 (12-hour mode), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 1 to 12. Hour 11 steps to 12 and toggles the PM flag, and hour 12 steps to 1. Only the step from 11 PM to 12 AM counts as midnight. Bit 6 never changes except by a write.
- R5: The day of week (bits 2:0) steps at midnight and wraps from 7 back to 1.
- R6: The day of month rolls from the last day back to 01 at midnight. The last day is 31, except 30 for months 04, 06, 09 and 11, and for month 02 it is 29 when the BCD year is divisible by 4 and 28 otherwise.
- R7: The month (bits 4:0) steps after its last day, and month 12 wraps to 01 with a step of the year. The year wrap from 99 to 00 inverts month bit 7 (the century flag).
- R8: One second takes 2^DIV_BITS accepted enable pulses. Clock cycles without an enable pulse do not count.
- R9: A write to seconds clears the divider. The square-wave phase is then low, rises after 2^(DIV_BITS-1) enable pulses, and the next seconds step happens on the 2^DIV_BITS-th enable pulse.
- R10: While halt_i is high and no write occurs, the divider, the square-wave phase and all time fields hold their values.
- R11: In a cycle with an accepted write, no field advances. The written byte appears on its output in the next cycle.
- R12: Write select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Code 7 is ignored and changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 1 | One-cycle pulse at 32.768 kHz rate |
| halt_i | input | 1 | Stops divider and timekeeping while high |
| wr_en_i | input | 1 | Host field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Byte to load into the selected field |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM/tens bits |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD, bit 7 century flag |
| year_o | output | 8 | Year, BCD |
| sqw_o | output | 1 | 1 Hz square-wave phase |

## Verification
The bench builds the block with DIV_BITS = 4, so one second lasts sixteen enable pulses. At that setting, every carry from seconds up to the century flag is reached within a few dozen cycles of a host load. The narrow divider also lets the bench count the exact enable pulses from a seconds write to the half-second phase edge and to the next step. A stretch with sparse enable pulses and a halted stretch show that only accepted pulses move the divider.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_MDAY = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } field_sel_e;

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int unsigned DIV_BITS = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o,
  output logic phase_o
);
  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = en_i & (&cnt_q);
  assign phase_o = cnt_q[DIV_BITS-1];
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] LAST = W'(8'h59),
  parameter logic [W-1:0] FIRST = '0
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int unsigned HW = W - 4;
  logic [HW-1:0] hi;
  logic [3:0]    lo;

  assign hi     = val_i[W-1:4];
  assign lo     = val_i[3:0];
  assign wrap_o = (val_i == LAST);

  always_comb begin
    if (wrap_o)         nxt_o = FIRST;
    else if (lo == 4'd9) nxt_o = {hi + 1'b1, 4'd0};
    else                nxt_o = {hi, lo + 4'd1};
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [6:0] hour_i,
  output logic [7:0] nxt_o,
  output logic       midnight_o
);
  logic       mode12, pm;
  logic [4:0] h12_inc;
  logic [5:0] h24_inc;

  assign mode12 = hour_i[6];
  assign pm     = hour_i[5];

  assign h12_inc = (hour_i[3:0] == 4'd9) ? {1'b1, 4'd0} : {hour_i[4], hour_i[3:0] + 4'd1};
  assign h24_inc = (hour_i[3:0] == 4'd9) ? {hour_i[5:4] + 2'd1, 4'd0}
                                         : {hour_i[5:4], hour_i[3:0] + 4'd1};

  always_comb begin
    midnight_o = 1'b0;
    if (mode12) begin
      if (hour_i[4:0] == 5'h11) begin
        nxt_o      = {2'b01, ~pm, 5'h12};
        midnight_o = pm;
      end else if (hour_i[4:0] == 5'h12) begin
        nxt_o = {2'b01, pm, 5'h01};
      end else begin
        nxt_o = {2'b01, pm, h12_inc};
      end
    end else if (hour_i[5:0] == 6'h23) begin
      nxt_o      = 8'h00;
      midnight_o = 1'b1;
    end else begin
      nxt_o = {2'b00, h24_inc};
    end
  end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
  import rtc_cal_pkg::*;
(
  input  logic [7:0] mday_i,
  input  logic [4:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] nxt_o,
  output logic       last_o
);
  logic [6:0] year_bin;
  logic       leap;
  logic [7:0] last_day;

  assign year_bin = 7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0]);
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign last_o = (mday_i == last_day);
  assign nxt_o  = last_o ? 8'h01 : bcd_inc8(mday_i);
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned DIV_BITS = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       halt_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       sqw_o
);
  field_sel_e sel;
  logic wr_hit, sec_wr, sec_tick;
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic [7:0] sec_nxt, min_nxt, hour_nxt, mday_nxt, year_nxt;
  logic [4:0] mon_nxt;
  logic sec_wrap, min_wrap, mon_wrap, year_wrap, hour_mid, mday_last;
  logic adv_sec, adv_min, adv_hour, adv_day, adv_mon, adv_year, flip_cent;

  assign sel    = field_sel_e'(wr_sel_i);
  assign wr_hit = wr_en_i && (sel != SEL_NONE);
  assign sec_wr = wr_hit && (sel == SEL_SEC);

  rtc_subsec_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (osc_en_i & ~halt_i),
    .clr_i   (sec_wr),
    .tick_o  (sec_tick),
    .phase_o (sqw_o)
  );

  rtc_bcd_wrap #(.W(8), .LAST(8'h59), .FIRST(8'h00)) u_sec (
    .val_i(sec_q), .nxt_o(sec_nxt), .wrap_o(sec_wrap));
  rtc_bcd_wrap #(.W(8), .LAST(8'h59), .FIRST(8'h00)) u_min (
    .val_i(min_q), .nxt_o(min_nxt), .wrap_o(min_wrap));
  rtc_bcd_wrap #(.W(5), .LAST(5'h12), .FIRST(5'h01)) u_mon (
    .val_i(mon_q[4:0]), .nxt_o(mon_nxt), .wrap_o(mon_wrap));
  rtc_bcd_wrap #(.W(8), .LAST(8'h99), .FIRST(8'h00)) u_year (
    .val_i(year_q), .nxt_o(year_nxt), .wrap_o(year_wrap));

  rtc_hour_step u_hour (
    .hour_i(hour_q[6:0]), .nxt_o(hour_nxt), .midnight_o(hour_mid));

  rtc_date_step u_date (
    .mday_i(mday_q), .mon_i(mon_q[4:0]), .year_i(year_q),
    .nxt_o(mday_nxt), .last_o(mday_last));

  // carry chain; any accepted write suppresses the whole step
  assign adv_sec   = sec_tick & ~wr_hit;
  assign adv_min   = adv_sec & sec_wrap;
  assign adv_hour  = adv_min & min_wrap;
  assign adv_day   = adv_hour & hour_mid;
  assign adv_mon   = adv_day & mday_last;
  assign adv_year  = adv_mon & mon_wrap;
  assign flip_cent = adv_year & year_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      wday_q <= 8'h01;
      mday_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_hit) begin
      case (sel)
        SEL_SEC:  sec_q  <= wr_data_i;
        SEL_MIN:  min_q  <= wr_data_i;
        SEL_HOUR: hour_q <= wr_data_i;
        SEL_WDAY: wday_q <= wr_data_i;
        SEL_MDAY: mday_q <= wr_data_i;
        SEL_MON:  mon_q  <= wr_data_i;
        SEL_YEAR: year_q <= wr_data_i;
        default:  ;
      endcase
    end else begin
      if (adv_sec)  sec_q  <= sec_nxt;
      if (adv_min)  min_q  <= min_nxt;
      if (adv_hour) hour_q <= hour_nxt;
      if (adv_day) begin
        wday_q <= {5'd0, (wday_q[2:0] == 3'd7) ? 3'd1 : wday_q[2:0] + 3'd1};
        mday_q <= mday_nxt;
      end
      if (adv_mon)  mon_q  <= {mon_q[7] ^ flip_cent, mon_q[6:5], mon_nxt};
      if (adv_year) year_q <= year_nxt;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign wday_o = wday_q;
  assign mday_o = mday_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       sqw_o
);
  logic wr_any;
  assign wr_any = wr_en_i && (wr_sel_i != 3'd7);

  assert_sec_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> (sec_o == $past(sec_o)) || (sec_o[3:0] == 4'd0) ||
                (sec_o[3:0] == $past(sec_o[3:0]) + 4'd1));

  assert_mode_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> $stable(hour_o[6]));

  assert_century_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> ((mon_o[7] != $past(mon_o[7])) ==
                 (year_o == 8'h00 && $past(year_o) == 8'h99)));

  assert_sqw_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> !sqw_o);

  assert_halt_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wr_any) |=> $stable(sec_o) && $stable(min_o) && $stable(sqw_o));

  assert_write_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> sec_o == $past(wr_data_i));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .halt_i    (halt_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .mon_o     (mon_o),
  .year_o    (year_o),
  .sqw_o     (sqw_o)
);

// File: tb/rtc_bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb_top;
  localparam int DIVB = 4;
  localparam int PER  = 1 << DIVB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b1, halt = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec, min, hour, wday, mday, mon, year;
  logic sqw;

  int n_cmp = 0, n_bad = 0;
  bit run_cmp = 0, done = 0;

  always #4 clk = ~clk;

  rtc_bcd_calendar #(.DIV_BITS(DIVB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .halt_i(halt),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday),
    .mday_o(mday), .mon_o(mon), .year_o(year), .sqw_o(sqw));

  // behavioural reference state
  int m_div, m_s, m_m, m_h, m_pm, m_12, m_wd, m_d, m_mo, m_y, m_c;

  function automatic logic [7:0] i2b(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction
  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int month_len(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_div = 0; m_s = 0; m_m = 0; m_h = 0; m_pm = 0; m_12 = 0;
    m_wd = 1; m_d = 1; m_mo = 1; m_y = 0; m_c = 0;
  endtask

  task automatic model_second();
    bit mid;
    mid = 0;
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0;
    if (m_12 != 0) begin
      if (m_h == 11) begin m_h = 12; m_pm = 1 - m_pm; mid = (m_pm == 0); end
      else if (m_h == 12) m_h = 1;
      else m_h++;
    end else begin
      m_h++;
      if (m_h == 24) begin m_h = 0; mid = 1; end
    end
    if (!mid) return;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_d++;
    if (m_d <= month_len(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y == 100) begin m_y = 0; m_c = 1 - m_c; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit valid_wr, due;
      valid_wr = wr_en && (wr_sel != 3'd7);
      due = 0;
      if (valid_wr && wr_sel == 3'd0) m_div = 0;
      else if (osc_en && !halt) begin
        if (m_div == PER - 1) begin m_div = 0; due = 1; end
        else m_div++;
      end
      if (valid_wr) begin
        case (wr_sel)
          3'd0: m_s = b2i(wr_data);
          3'd1: m_m = b2i(wr_data);
          3'd2: begin
            m_12 = wr_data[6];
            if (wr_data[6]) begin m_pm = wr_data[5]; m_h = b2i({3'b0, wr_data[4:0]}); end
            else begin m_pm = 0; m_h = b2i({2'b0, wr_data[5:0]}); end
          end
          3'd3: m_wd = int'(wr_data[2:0]);
          3'd4: m_d = b2i(wr_data);
          3'd5: begin m_c = wr_data[7]; m_mo = b2i({3'b0, wr_data[4:0]}); end
          default: m_y = b2i(wr_data);
        endcase
      end else if (due) model_second();
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_hour();
    if (m_12 != 0) return 8'h40 | (m_pm != 0 ? 8'h20 : 8'h00) | i2b(m_h);
    return i2b(m_h);
  endfunction

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk("R2", "sec", sec, i2b(m_s));
      chk("R2", "min", min, i2b(m_m));
      chk(m_12 != 0 ? "R4" : "R3", "hour", hour, exp_hour());
      chk("R5", "wday", wday, 8'(m_wd));
      chk("R6", "mday", mday, i2b(m_d));
      chk("R7", "mon", mon, (m_c != 0 ? 8'h80 : 8'h00) | i2b(m_mo));
      chk("R7", "year", year, i2b(m_y));
      chk("R9", "sqw", {7'd0, sqw}, {7'd0, m_div >= PER / 2});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(logic [7:0] h, logic [7:0] mi, logic [7:0] s, logic [7:0] wd,
                      logic [7:0] md, logic [7:0] mo, logic [7:0] y);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd3, wd); wr(3'd4, md);
    wr(3'd5, mo); wr(3'd6, y); wr(3'd0, s);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int n;
    logic [7:0] s0, m0, h0, d0;
    logic q0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1", "sec", sec, 8'h00);  chk("R1", "min", min, 8'h00);
    chk("R1", "hour", hour, 8'h00); chk("R1", "wday", wday, 8'h01);
    chk("R1", "mday", mday, 8'h01); chk("R1", "mon", mon, 8'h01);
    chk("R1", "year", year, 8'h00); chk("R1", "sqw", {7'd0, sqw}, 8'h00);
    run_cmp = 1;
    idle(40);

    // R8 / R9: pulses from seconds write to phase edge and next step
    wr(3'd0, 8'h10);
    n = 0;
    while (sqw == 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk("R9", "enables to phase rise", 8'(n), 8'(PER / 2));
    while (sec == 8'h10 && n < 100) begin @(negedge clk); n++; end
    chk("R8", "enables per second", 8'(n), 8'(PER));
    chk("R8", "sec after one second", sec, 8'h11);

    // R11: write collides with the tick
    wr(3'd0, 8'h30);
    idle(PER - 1);
    wr(3'd1, 8'h07);
    chk("R11", "sec held on collision", sec, 8'h30);
    chk("R11", "min written", min, 8'h07);
    idle(PER + 2);
    chk("R11", "sec resumes", sec, 8'h31);

    // R3: 24-hour non-midnight carry
    load(8'h09, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h45);
    idle(PER + 2);
    chk("R3", "hour 09->10", hour, 8'h10);

    // R7 / R5: year and century rollover
    load(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
    idle(PER + 2);
    chk("R7", "century month", mon, 8'h81);
    chk("R7", "year wrap", year, 8'h00);
    chk("R5", "wday wrap", wday, 8'h01);
    chk("R6", "mday wrap", mday, 8'h01);

    // R6: month lengths and leap years
    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    idle(PER + 2);
    chk("R6", "leap 24 feb29", mday, 8'h29);
    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h29, 8'h02, 8'h24);
    idle(PER + 2);
    chk("R6", "leap 24 mar1", mon, 8'h03);
    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23);
    idle(PER + 2);
    chk("R6", "common 23 mar1", mday, 8'h01);
    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h00);
    idle(PER + 2);
    chk("R6", "year 00 feb29", mday, 8'h29);
    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h10);
    idle(PER + 2);
    chk("R6", "apr30 to may", mon, 8'h05);

    // R4: 12-hour sequence
    load(8'h51, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h31);
    idle(PER + 2);
    chk("R4", "11AM->12PM", hour, 8'h72);
    chk("R4", "no date step at noon", mday, 8'h15);
    load(8'h72, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h31);
    idle(PER + 2);
    chk("R4", "12PM->1PM", hour, 8'h61);
    load(8'h71, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h31);
    idle(PER + 2);
    chk("R4", "11PM->12AM", hour, 8'h52);
    chk("R4", "midnight date", mday, 8'h16);
    chk("R5", "midnight wday", wday, 8'h04);

    // R8: sparse enables
    for (int i = 0; i < 3 * PER * 3; i++) begin
      osc_en = (i % 3 == 0);
      @(negedge clk);
    end
    osc_en = 1'b1;

    // R10: halt freezes
    halt = 1'b1;
    @(negedge clk);
    s0 = sec; m0 = min; q0 = sqw;
    idle(3 * PER);
    chk("R10", "sec frozen", sec, s0);
    chk("R10", "min frozen", min, m0);
    chk("R10", "sqw frozen", {7'd0, sqw}, {7'd0, q0});

    // R12: select 7 ignored (while halted so nothing else moves)
    s0 = sec; m0 = min; h0 = hour; d0 = mday;
    wr(3'd7, 8'h00);
    idle(2);
    chk("R12", "sec", sec, s0);   chk("R12", "min", min, m0);
    chk("R12", "hour", hour, h0); chk("R12", "mday", mday, d0);
    halt = 1'b0;
    idle(3 * PER);

    done = 1;
    summary();
  end
endmodule